// File: doc/BRIEF.md
# Vector Floating-Point Sign-Injection Unit

This block performs the three sign-injection operations on a packed vector register, one element at a time. Each result element takes its exponent and mantissa bits from the first vector source. Its sign bit is built from the second operand in one of three ways: the second operand's sign is copied, inverted, or XORed with the first source's sign. The element width can be changed at run time to 16, 32 or 64 bits. The second operand is either a full vector or one 64-bit scalar whose low element-width bits are broadcast to every element.

The unit decodes a 32-bit instruction word to select the operation and the operand form. It then applies the active vector length and an optional mask, and registers a packed result with one write enable per element. The result register, its write enables and a done strobe update one clock after an input strobe. Instruction words that match none of the six supported encodings raise an illegal flag and do not write. Register storage and floating-point exception flags belong to the surrounding datapath.

Top module: `sgnj_unit`

## Requirements
- R1: A word is legal only when all of these hold: bits 6:0 equal 1010111; bits 31:26 are 001000, 001001 or 001010; bits 14:12 are 001 or 101; and `ew_sel` is not 3. An illegal word gives `res_illegal`=1 with `res_done`, all `res_we` bits 0, and `res_data` unchanged.
- R2: In each computed element, every bit below the sign bit equals the same bits of the `vs2_data` element.
- R3: With bits 31:26 = 001000, the result sign equals the second operand's sign.
- R4: With bits 31:26 = 001001, the result sign is the inverse of the second operand's sign.
- R5: With bits 31:26 = 001010, the result sign is the XOR of the second operand's sign and the `vs2_data` element's sign.
- R6: `ew_sel` 0, 1 and 2 select 16, 32 and 64-bit elements. Element i occupies bits [i*EW +: EW], and its sign is the top bit of that slice.
- R7: Bits 14:12 = 001 take the second operand from the same element of `vs1_data`. Bits 14:12 = 101 take it from `scalar[EW-1:0]` for every element.
- R8: An element with index i >= `vl` is a tail element. Its result is zero and its `res_we` bit is 1. A `vl` above the element count makes every element active.
- R9: Bit 25 = 0 enables masking. An active element i whose `mask[i]` is 0 then takes the `vd_old` element, and its `res_we` bit is 0. Bit 25 = 1 ignores `mask`.
- R10: `res_done` is 1 exactly in the cycle after a cycle with `in_valid` = 1. While `res_done` is 0, `res_we` is all zero and `res_data` holds its value.
- R11: While reset is asserted, all outputs are zero.
- R12: `res_vd` shows bits 11:7 of the last legal word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: operands and word are present |
| instr | input | 32 | Instruction word |
| ew_sel | input | 2 | Element width select (0:16, 1:32, 2:64) |
| vl | input | VL_W | Active vector length in elements |
| vs2_data | input | VLEN | First vector source |
| vs1_data | input | VLEN | Second vector source |
| scalar | input | 64 | Scalar second operand |
| mask | input | MAX_E | Mask bit per element index |
| vd_old | input | VLEN | Old destination contents |
| res_data | output | VLEN | Registered packed result |
| res_we | output | MAX_E | Write enable per element index |
| res_done | output | 1 | Result strobe |
| res_illegal | output | 1 | Word not recognised |
| res_vd | output | 5 | Destination register index |

## Verification
Every result of this unit is due exactly one clock edge after the strobe. This covers data, write enables, done, the illegal flag and the destination index. The bench drives a strobe on a falling edge, drops it on the next falling edge, and samples all outputs at that point. It takes one more sample a cycle later to confirm that done and the write enables have fallen while the data holds. A reset that arrives mid-run is checked a fraction of a cycle after it is asserted, because it clears the outputs without waiting for a clock.

// File: rtl/sgnj_pkg.sv
package sgnj_pkg;

  localparam logic [6:0] OPC_VFP     = 7'b1010111;
  localparam logic [5:0] F6_COPY     = 6'b001000;
  localparam logic [5:0] F6_FLIP     = 6'b001001;
  localparam logic [5:0] F6_XOR      = 6'b001010;
  localparam logic [2:0] F3_VECVEC   = 3'b001;
  localparam logic [2:0] F3_VECSCAL  = 3'b101;
  localparam int         SCAL_W      = 64;

  typedef enum logic [1:0] {
    SGN_COPY = 2'd0,
    SGN_FLIP = 2'd1,
    SGN_XOR  = 2'd2,
    SGN_NONE = 2'd3
  } sgn_op_e;

  typedef struct packed {
    logic    legal;
    sgn_op_e op;
    logic    scalar_form;
    logic    mask_on;
    logic [4:0] vd;
  } sgn_ctrl_t;

endpackage

// File: rtl/sgnj_decode.sv
module sgnj_decode
  import sgnj_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [1:0]  ew_sel,
  output sgn_ctrl_t   ctrl
);

  logic [5:0] f6;
  logic [2:0] f3;
  logic       form_ok;
  logic       unused_fields;

  assign f6 = instr[31:26];
  assign f3 = instr[14:12];
  assign unused_fields = ^instr[24:15];

  always_comb begin
    ctrl.op = SGN_NONE;
    case (f6)
      F6_COPY: ctrl.op = SGN_COPY;
      F6_FLIP: ctrl.op = SGN_FLIP;
      F6_XOR:  ctrl.op = SGN_XOR;
      default: ctrl.op = SGN_NONE;
    endcase
    form_ok          = (f3 == F3_VECVEC) || (f3 == F3_VECSCAL);
    ctrl.scalar_form = (f3 == F3_VECSCAL);
    ctrl.mask_on     = ~instr[25];
    ctrl.vd          = instr[11:7];
    ctrl.legal       = (instr[6:0] == OPC_VFP) && (ctrl.op != SGN_NONE) &&
                       form_ok && (ew_sel != 2'd3);
  end

endmodule

// File: rtl/sgnj_elem.sv
module sgnj_elem
  import sgnj_pkg::*;
#(
  parameter int EW = 32
) (
  input  sgn_op_e       op,
  input  logic [EW-1:0] a,
  input  logic          b_sign,
  output logic [EW-1:0] r
);

  logic s;

  always_comb begin
    case (op)
      SGN_COPY: s = b_sign;
      SGN_FLIP: s = ~b_sign;
      SGN_XOR:  s = a[EW-1] ^ b_sign;
      default:  s = a[EW-1];
    endcase
  end

  assign r = {s, a[EW-2:0]};

endmodule

// File: rtl/sgnj_ew_path.sv
module sgnj_ew_path
  import sgnj_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int EW    = 32,
  parameter int MAX_E = 8,
  parameter int VL_W  = 4,
  localparam int NE   = VLEN / EW
) (
  input  sgn_op_e           op,
  input  logic              scalar_form,
  input  logic              mask_on,
  input  logic [VL_W-1:0]   vl,
  input  logic [VLEN-1:0]   vs2,
  input  logic [VLEN-1:0]   vs1,
  input  logic [VLEN-1:0]   old,
  input  logic [SCAL_W-1:0] scalar,
  input  logic [MAX_E-1:0]  mask,
  output logic [VLEN-1:0]   data,
  output logic [MAX_E-1:0]  we
);

  logic unused_bits;
  assign unused_bits = ^{vs1, scalar, mask};

  for (genvar i = 0; i < NE; i++) begin : g_el
    logic [EW-1:0] a;
    logic [EW-1:0] r;
    logic          b_sign;
    logic          tail;
    logic          keep;

    assign a      = vs2[i*EW +: EW];
    assign b_sign = scalar_form ? scalar[EW-1] : vs1[i*EW + EW - 1];

    sgnj_elem #(.EW(EW)) u_elem (
      .op     (op),
      .a      (a),
      .b_sign (b_sign),
      .r      (r)
    );

    // R8 tail, R9 mask
    assign tail = (int'(vl) <= i);
    assign keep = mask_on && !mask[i];
    assign data[i*EW +: EW] = tail ? '0 : (keep ? old[i*EW +: EW] : r);
    assign we[i] = tail | ~keep;
  end

  if (MAX_E > NE) begin : g_we_pad
    assign we[MAX_E-1:NE] = '0;
  end

endmodule

// File: rtl/sgnj_unit.sv
module sgnj_unit
  import sgnj_pkg::*;
#(
  parameter int VLEN   = 128,
  localparam int MAX_E = VLEN / 16,
  localparam int VL_W  = $clog2(MAX_E + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [1:0]        ew_sel,
  input  logic [VL_W-1:0]   vl,
  input  logic [VLEN-1:0]   vs2_data,
  input  logic [VLEN-1:0]   vs1_data,
  input  logic [SCAL_W-1:0] scalar,
  input  logic [MAX_E-1:0]  mask,
  input  logic [VLEN-1:0]   vd_old,
  output logic [VLEN-1:0]   res_data,
  output logic [MAX_E-1:0]  res_we,
  output logic              res_done,
  output logic              res_illegal,
  output logic [4:0]        res_vd
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s0, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_q_n <= rst_s0;
    end
  end

  sgn_ctrl_t ctrl;
  sgnj_decode u_dec (
    .instr  (instr),
    .ew_sel (ew_sel),
    .ctrl   (ctrl)
  );

  logic [VLEN-1:0]  path_data [3];
  logic [MAX_E-1:0] path_we   [3];

  for (genvar k = 0; k < 3; k++) begin : g_ew
    sgnj_ew_path #(
      .VLEN  (VLEN),
      .EW    (16 << k),
      .MAX_E (MAX_E),
      .VL_W  (VL_W)
    ) u_path (
      .op          (ctrl.op),
      .scalar_form (ctrl.scalar_form),
      .mask_on     (ctrl.mask_on),
      .vl          (vl),
      .vs2         (vs2_data),
      .vs1         (vs1_data),
      .old         (vd_old),
      .scalar      (scalar),
      .mask        (mask),
      .data        (path_data[k]),
      .we          (path_we[k])
    );
  end

  logic [VLEN-1:0]  data_q, data_n;
  logic [MAX_E-1:0] we_q, we_n;
  logic             done_q, done_n;
  logic             ill_q, ill_n;
  logic [4:0]       vd_q, vd_n;
  logic             upd_en;

  always_comb begin
    upd_en = in_valid & ctrl.legal;
    data_n = data_q;
    we_n   = '0;
    ill_n  = 1'b0;
    done_n = in_valid;
    vd_n   = vd_q;
    if (upd_en) begin
      case (ew_sel)
        2'd0:    begin data_n = path_data[0]; we_n = path_we[0]; end
        2'd1:    begin data_n = path_data[1]; we_n = path_we[1]; end
        default: begin data_n = path_data[2]; we_n = path_we[2]; end
      endcase
      vd_n = ctrl.vd;
    end else if (in_valid) begin
      ill_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      data_q <= '0;
      we_q   <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      vd_q   <= '0;
    end else begin
      done_q <= done_n;
      we_q   <= we_n;
      ill_q  <= ill_n;
      if (upd_en) begin
        data_q <= data_n;
        vd_q   <= vd_n;
      end
    end
  end

  assign res_data    = data_q;
  assign res_we      = we_q;
  assign res_done    = done_q;
  assign res_illegal = ill_q;
  assign res_vd      = vd_q;

  AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> res_done); // R10
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> (!res_done && res_we == '0 && $stable(res_data))); // R10
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    res_illegal |-> (res_done && res_we == '0)); // R1
  AST_ILLEGAL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !ctrl.legal) |=> $stable(res_data)); // R1
  AST_MAG_FROM_VS2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && ctrl.legal && ew_sel == 2'd2 && vl != '0 && !ctrl.mask_on)
      |=> (res_data[62:0] == $past(vs2_data[62:0]))); // R2
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && ctrl.legal && vl == '0) |=> (res_data == '0)); // R8

endmodule

// File: tb/tb_sgnj_unit.sv
module tb_sgnj_unit;

  localparam int VLEN = 128;
  localparam int ME   = VLEN / 16;
  localparam int VLW  = $clog2(ME + 1);
  localparam logic [VLEN-1:0] OLD = 128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1357_9BDF;

  typedef struct packed {
    logic [1:0]      op;    // 0 copy, 1 flip, 2 xor
    logic            form;  // 0 vector-vector, 1 vector-scalar
    logic            vm;    // bit 25
    logic [1:0]      sew;
    logic [3:0]      vl;
    logic [7:0]      mask;
    logic [127:0]    vs2;
    logic [127:0]    vs1;
    logic [63:0]     scal;
  } ent_t;

  localparam int NT = 10;
  localparam ent_t TBL [NT] = '{
    '{2'd0, 1'b0, 1'b1, 2'd0, 4'd8,  8'h00, 128'h8001_7FFF_1234_F0F0_0000_8000_ABCD_5555, 128'hFFFF_0000_8000_7FFF_8000_0000_0001_F000, 64'h0},
    '{2'd1, 1'b0, 1'b1, 2'd1, 4'd4,  8'h00, 128'h8000_0001_7F80_0000_0000_0000_C0DE_CAFE, 128'h0000_0000_8000_0000_7FFF_FFFF_FFFF_FFFF, 64'h0},
    '{2'd2, 1'b0, 1'b1, 2'd2, 4'd2,  8'h00, 128'hFFF0_0000_0000_0000_3FF0_0000_0000_0001, 128'h8000_0000_0000_0000_8000_0000_0000_0000, 64'h0},
    '{2'd0, 1'b1, 1'b1, 2'd0, 4'd5,  8'h00, 128'h1111_9222_3333_C444_5555_6666_F777_0888, 128'h0, 64'h0000_0000_0000_8000},
    '{2'd1, 1'b1, 1'b1, 2'd2, 4'd1,  8'h00, 128'h0123_4567_89AB_CDEF_8000_0000_0000_0000, 128'h0, 64'hC000_0000_0000_0000},
    '{2'd2, 1'b1, 1'b0, 2'd1, 4'd4,  8'h05, 128'h8111_1111_0222_2222_8333_3333_0444_4444, 128'h0, 64'h1234_5678_8000_0000},
    '{2'd2, 1'b0, 1'b0, 2'd0, 4'd6,  8'hA5, 128'hF00D_0BAD_8BAD_7EED_FACE_0001_8000_FFFF, 128'h8000_8000_0000_0000_8000_FFFF_8000_0000, 64'h0},
    '{2'd0, 1'b0, 1'b1, 2'd1, 4'd0,  8'h00, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'h0, 64'h0},
    '{2'd1, 1'b0, 1'b1, 2'd0, 4'd15, 8'h00, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h8000_0000_8000_0000_8000_0000_8000_0000, 64'h0},
    '{2'd0, 1'b1, 1'b0, 2'd2, 4'd2,  8'h02, 128'h7FFF_FFFF_FFFF_FFFF_0000_0000_0000_0000, 128'h0, 64'h8000_0000_0000_0000}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     instr;
  logic [1:0]      ew_sel;
  logic [VLW-1:0]  vl;
  logic [VLEN-1:0] vs2_data, vs1_data, vd_old;
  logic [63:0]     scalar;
  logic [ME-1:0]   mask;
  logic [VLEN-1:0] res_data;
  logic [ME-1:0]   res_we;
  logic            res_done, res_illegal;
  logic [4:0]      res_vd;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sgnj_unit #(.VLEN(VLEN)) dut (
    .clk, .rst_n, .in_valid, .instr, .ew_sel, .vl, .vs2_data, .vs1_data,
    .scalar, .mask, .vd_old, .res_data, .res_we, .res_done, .res_illegal, .res_vd
  );

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [1:0] op, logic form, logic vm, logic [4:0] vd);
    logic [5:0] f6;
    f6 = (op == 2'd0) ? 6'b001000 : (op == 2'd1) ? 6'b001001 : 6'b001010;
    return {f6, vm, 5'd3, 5'd17, (form ? 3'b101 : 3'b001), vd, 7'b1010111};
  endfunction

  // independent model of the requirements
  task automatic model(input ent_t e, output logic [VLEN-1:0] d, output logic [ME-1:0] w);
    int ew, ne;
    logic [63:0] m, a, b, r;
    logic sa, sb, s;
    ew = 16 << e.sew;
    ne = VLEN / ew;
    m  = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
    d = '0;
    w = '0;
    for (int i = 0; i < ne; i++) begin
      a  = 64'(e.vs2 >> (i * ew)) & m;
      b  = e.form ? (e.scal & m) : (64'(e.vs1 >> (i * ew)) & m);
      sa = a[ew-1];
      sb = b[ew-1];
      case (e.op)
        2'd0: s = sb;
        2'd1: s = ~sb;
        default: s = sa ^ sb;
      endcase
      r = (a & (m >> 1)) | (64'(s) << (ew - 1));
      if (i >= int'(e.vl)) begin
        r = 64'd0; w[i] = 1'b1;
      end else if (!e.vm && !e.mask[i]) begin
        r = 64'(OLD >> (i * ew)) & m; w[i] = 1'b0;
      end else begin
        w[i] = 1'b1;
      end
      d = d | (VLEN'(r) << (i * ew));
    end
  endtask

  task automatic apply(logic [31:0] iw, logic [1:0] s, logic [VLW-1:0] l, logic [ME-1:0] mk_bits,
                       logic [VLEN-1:0] a, logic [VLEN-1:0] b, logic [63:0] sc);
    instr = iw; ew_sel = s; vl = l; mask = mk_bits;
    vs2_data = a; vs1_data = b; scalar = sc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] ed, held;
    logic [ME-1:0]   ew_exp;
    string tg;
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; ew_sel = '0; vl = '0;
    vs2_data = '0; vs1_data = '0; scalar = '0; mask = '0; vd_old = OLD;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 data", res_data, '0);
    check("R11 flags", {res_we, res_done, res_illegal, res_vd}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int t = 0; t < NT; t++) begin
      model(TBL[t], ed, ew_exp);
      apply(mk(TBL[t].op, TBL[t].form, TBL[t].vm, 5'(t + 1)), TBL[t].sew, VLW'(TBL[t].vl),
            TBL[t].mask, TBL[t].vs2, TBL[t].vs1, TBL[t].scal);
      tg = $sformatf("entry %0d R2 R6 %s%s%s%s", t,
                     (TBL[t].op == 0) ? "R3" : (TBL[t].op == 1) ? "R4" : "R5",
                     TBL[t].form ? " R7" : "", TBL[t].vm ? "" : " R9",
                     (int'(TBL[t].vl) < (VLEN >> (4 + TBL[t].sew))) ? " R8" : "");
      check({tg, " data"}, res_data, ed);
      check({tg, " we"}, 128'(res_we), 128'(ew_exp));
      check($sformatf("entry %0d R10 done/illegal", t), {res_done, res_illegal}, 2'b10);
      check($sformatf("entry %0d R12 vd", t), res_vd, 5'(t + 1));
    end

    // R10: one-cycle done, data held afterwards
    held = res_data;
    @(negedge clk);
    check("R10 done drops", {res_done, res_we}, '0);
    check("R10 data held", res_data, held);

    // R1 illegal encodings
    apply({mk(2'd0, 1'b0, 1'b1, 5'd20)} ^ 32'h0000_0004, 2'd0, 4'd8, '0, '1, '0, '0);
    check("R1 bad opcode", {res_illegal, res_done, res_we}, {2'b11, 8'h00});
    check("R1 bad opcode data", res_data, held);
    apply({6'b001011, mk(2'd0, 1'b0, 1'b1, 5'd20)} >> 0 & 32'hFFFF_FFFF ^ 32'h0C00_0000, 2'd0, 4'd8, '0, '1, '0, '0);
    check("R1 bad funct6", {res_illegal, res_we}, {1'b1, 8'h00});
    apply(mk(2'd2, 1'b0, 1'b1, 5'd20) & ~32'h0000_7000, 2'd1, 4'd8, '0, '1, '0, '0);
    check("R1 bad form", {res_illegal, res_we}, {1'b1, 8'h00});
    apply(mk(2'd1, 1'b1, 1'b1, 5'd20), 2'd3, 4'd8, '0, '1, '0, '0);
    check("R1 bad width", {res_illegal, res_we}, {1'b1, 8'h00});
    check("R1 data and vd unchanged", {res_data, 5'd0} ^ 133'(res_vd), {held, 5'd0} ^ 133'd10);

    // R11 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    check("R11 mid-run reset", {res_data, res_we, res_done, res_illegal, res_vd}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule